// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is the execution stage of a subword-parallel integer unit. It reads two 64-bit operands and treats each as a row of independent integer elements, 8, 16, 32 or 64 bits wide. On each strobe it performs one operation on every element at once. The operations cover add and subtract in wrapping or clamping form, lane-mask compares, 16-bit multiplies, a multiply with pairwise sum, narrowing with clamping, interleaving of lower or upper halves, per-element shifts and whole-word bitwise logic.

The result is registered. It appears one cycle after the input strobe, together with an output valid. An operation code is combined with a lane-size code, and a combination with no defined meaning gives a zero result and a one-cycle error pulse. Operand storage, instruction decode and memory traffic belong to the surrounding pipeline.

Top module: `simd_alu`

## Requirements
- R1: After reset `out_valid`, `illegal` and `result` are 0. A high `in_valid` at a rising edge puts the result on `result` and sets `out_valid` high after that same edge. A cycle without `in_valid` clears `out_valid` and leaves `result` unchanged.
- R2: `opcode` 0 adds and 1 subtracts element by element. `lane_sel` picks the element width: 0 for 8 bits, 1 for 16, 2 for 32. With `sat_sel` 0 each element wraps modulo its width, and no carry or borrow passes into the next element.
- R3: With `sat_sel` 1, add and subtract treat elements as two's-complement numbers. A result that overflows is clamped to the element's most negative or most positive value.
- R4: With `sat_sel` 2, add and subtract treat elements as unsigned numbers. A result above the range becomes all ones, and a result below zero becomes 0.
- R5: `opcode` 2 (equal) and `opcode` 3 (signed greater, a > b) set each element of width 8, 16 or 32 to all ones where the test holds and to all zeros where it does not.
- R6: `opcode` 4 and `opcode` 5 require `lane_sel` 1. They form the signed 32-bit product of each 16-bit element pair. Opcode 4 returns bits 15:0 of each product and opcode 5 returns bits 31:16, each in that element's position.
- R7: `opcode` 6 requires `lane_sel` 1. It forms the same four signed products and adds products 0 and 1 into result bits 31:0, and products 2 and 3 into bits 63:32.
- R8: `opcode` 7 narrows source elements of 16 bits (`lane_sel` 1) or 32 bits (`lane_sel` 2) to half width. The elements of `src_a` fill the lower half of the result and those of `src_b` the upper half, each in order. With `sat_sel` 0 or 1 the clamp is signed; with `sat_sel` 2 negative values become 0 and values too large become all ones.
- R9: `opcode` 8 interleaves the lower-half elements of the two sources, as a0, b0, a1, b1 and so on from bit 0 upward. `opcode` 9 does the same with the upper-half elements. Both accept `lane_sel` 0, 1 or 2.
- R10: `opcode` 10 shifts left and `opcode` 11 shifts right logically by `shamt`. The element width is 16, 32 or 64 (`lane_sel` 1, 2, 3), and no bit moves between elements. A count at or above the element width gives 0.
- R11: `opcode` 12 shifts right arithmetically on 16- or 32-bit elements and fills with each element's sign. A count at or above the element width gives every bit equal to the sign.
- R12: With `lane_sel` 3, opcodes 13, 14, 15 and 16 give a&b, (~a)&b, a|b and a^b over the whole 64-bit word.
- R13: Any pairing of opcode and `lane_sel` not listed above, any other opcode, or `sat_sel` 3 on add, subtract or narrow gives `result` 0 and raises `illegal` for the one cycle that shows that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| opcode | input | 5 | Operation select |
| lane_sel | input | 2 | Element width code |
| sat_sel | input | 2 | Wrap / signed clamp / unsigned clamp |
| shamt | input | 7 | Shift count |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Registered result |
| illegal | output | 1 | Undefined combination flag |

## Verification
The arithmetic is driven with operands whose sum crosses the top of an element, once under each saturation mode. Wrapping shows that no carry reaches the next element, and the two clamp modes give different outputs for the same bit pattern. Compares, multiplies and narrowing mix positive, negative and extreme values in neighbouring elements, so that a signed versus unsigned mistake or a swapped element moves a visible byte. Shift counts just below, at and above the element width separate normal shifting from the zero and sign-fill cases. Illegal pairings are followed by idle and legal cycles to show that the flag lasts one cycle.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD    = 5'd0,
        OP_SUB    = 5'd1,
        OP_CMPEQ  = 5'd2,
        OP_CMPGT  = 5'd3,
        OP_MULLO  = 5'd4,
        OP_MULHI  = 5'd5,
        OP_MADD   = 5'd6,
        OP_PACK   = 5'd7,
        OP_UNPKLO = 5'd8,
        OP_UNPKHI = 5'd9,
        OP_SHL    = 5'd10,
        OP_SHR    = 5'd11,
        OP_SAR    = 5'd12,
        OP_AND    = 5'd13,
        OP_ANDN   = 5'd14,
        OP_OR     = 5'd15,
        OP_XOR    = 5'd16
    } alu_op_e;

    localparam logic [1:0] LANE_B  = 2'd0;
    localparam logic [1:0] LANE_H  = 2'd1;
    localparam logic [1:0] LANE_W  = 2'd2;
    localparam logic [1:0] LANE_D  = 2'd3;

    localparam logic [1:0] SAT_WRAP = 2'd0;
    localparam logic [1:0] SAT_SGN  = 2'd1;
    localparam logic [1:0] SAT_USG  = 2'd2;
    localparam logic [1:0] SAT_BAD  = 2'd3;

    localparam logic [1:0] SH_LEFT  = 2'd0;
    localparam logic [1:0] SH_RLOG  = 2'd1;
    localparam logic [1:0] SH_RARI  = 2'd2;

endpackage

// File: rtl/simd_lane_arith.sv
module simd_lane_arith
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ELEM_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    input  logic [1:0]        sat_i,
    output logic [DATA_W-1:0] sum_o,
    output logic [DATA_W-1:0] eq_o,
    output logic [DATA_W-1:0] gt_o
);
    localparam int NL = DATA_W / ELEM_W;

    for (genvar i = 0; i < NL; i++) begin : g_el
        logic [ELEM_W-1:0] ea, eb, y;
        logic [ELEM_W:0]   s_ext, u_ext;

        assign ea = a_i[i*ELEM_W +: ELEM_W];
        assign eb = b_i[i*ELEM_W +: ELEM_W];

        // one extra bit: sign-extended for signed overflow, zero-extended for carry/borrow
        assign s_ext = sub_i ? ({ea[ELEM_W-1], ea} - {eb[ELEM_W-1], eb})
                             : ({ea[ELEM_W-1], ea} + {eb[ELEM_W-1], eb});
        assign u_ext = sub_i ? ({1'b0, ea} - {1'b0, eb})
                             : ({1'b0, ea} + {1'b0, eb});

        always_comb begin
            y = s_ext[ELEM_W-1:0];
            if (sat_i == SAT_SGN) begin
                if (s_ext[ELEM_W] != s_ext[ELEM_W-1])
                    y = s_ext[ELEM_W] ? {1'b1, {(ELEM_W-1){1'b0}}}
                                      : {1'b0, {(ELEM_W-1){1'b1}}};
            end else if (sat_i == SAT_USG) begin
                if (u_ext[ELEM_W])
                    y = sub_i ? '0 : '1;
                else
                    y = u_ext[ELEM_W-1:0];
            end
        end

        assign sum_o[i*ELEM_W +: ELEM_W] = y;
        assign eq_o[i*ELEM_W +: ELEM_W]  = {ELEM_W{ea == eb}};
        assign gt_o[i*ELEM_W +: ELEM_W]  = {ELEM_W{$signed(ea) > $signed(eb)}};
    end

endmodule

// File: rtl/simd_lane_shift.sv
module simd_lane_shift
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ELEM_W = 16,
    parameter int CNT_W  = 7
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [1:0]        kind_i,
    output logic [DATA_W-1:0] y_o
);
    localparam int NL = DATA_W / ELEM_W;

    logic big;
    assign big = (cnt_i >= CNT_W'(ELEM_W));

    for (genvar i = 0; i < NL; i++) begin : g_el
        logic [ELEM_W-1:0] ea, y;
        assign ea = a_i[i*ELEM_W +: ELEM_W];

        always_comb begin
            case (kind_i)
                SH_LEFT: y = big ? '0 : (ea << cnt_i);
                SH_RLOG: y = big ? '0 : (ea >> cnt_i);
                SH_RARI: y = big ? {ELEM_W{ea[ELEM_W-1]}}
                                 : ELEM_W'($signed(ea) >>> cnt_i);
                default: y = '0;
            endcase
        end

        assign y_o[i*ELEM_W +: ELEM_W] = y;
    end

endmodule

// File: rtl/simd_mul16.sv
module simd_mul16 #(
    parameter int DATA_W = 64,
    parameter int ELEM_W = 16
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] lo_o,
    output logic [DATA_W-1:0] hi_o,
    output logic [DATA_W-1:0] madd_o
);
    localparam int NL = DATA_W / ELEM_W;
    localparam int PW = 2 * ELEM_W;

    logic [PW-1:0] prod [NL];

    always_comb begin
        for (int i = 0; i < NL; i++) begin
            prod[i] = PW'($signed(a_i[i*ELEM_W +: ELEM_W]) * $signed(b_i[i*ELEM_W +: ELEM_W]));
            lo_o[i*ELEM_W +: ELEM_W] = prod[i][ELEM_W-1:0];
            hi_o[i*ELEM_W +: ELEM_W] = prod[i][PW-1:ELEM_W];
        end
        for (int j = 0; j < NL/2; j++) begin
            madd_o[j*PW +: PW] = prod[2*j] + prod[2*j+1];
        end
    end

endmodule

// File: rtl/simd_lane_permute.sv
module simd_lane_permute #(
    parameter int DATA_W = 64,
    parameter int ELEM_W = 16
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              usat_i,
    output logic [DATA_W-1:0] pack_o,
    output logic [DATA_W-1:0] unlo_o,
    output logic [DATA_W-1:0] unhi_o
);
    localparam int NL = DATA_W / ELEM_W;
    localparam int HW = ELEM_W / 2;

    function automatic logic [HW-1:0] narrow(input logic [ELEM_W-1:0] v, input logic uns);
        if (uns) begin
            if (v[ELEM_W-1])         return '0;
            else if (|v[ELEM_W-2:HW]) return '1;
            else                      return v[HW-1:0];
        end else begin
            if ((&v[ELEM_W-1:HW-1]) || !(|v[ELEM_W-1:HW-1])) return v[HW-1:0];
            else if (v[ELEM_W-1]) return {1'b1, {(HW-1){1'b0}}};
            else                  return {1'b0, {(HW-1){1'b1}}};
        end
    endfunction

    always_comb begin
        pack_o = '0;
        unlo_o = '0;
        unhi_o = '0;
        for (int i = 0; i < NL; i++) begin
            pack_o[i*HW +: HW]            = narrow(a_i[i*ELEM_W +: ELEM_W], usat_i);
            pack_o[DATA_W/2 + i*HW +: HW] = narrow(b_i[i*ELEM_W +: ELEM_W], usat_i);
        end
        for (int i = 0; i < NL/2; i++) begin
            unlo_o[(2*i)*ELEM_W +: ELEM_W]   = a_i[i*ELEM_W +: ELEM_W];
            unlo_o[(2*i+1)*ELEM_W +: ELEM_W] = b_i[i*ELEM_W +: ELEM_W];
            unhi_o[(2*i)*ELEM_W +: ELEM_W]   = a_i[(i+NL/2)*ELEM_W +: ELEM_W];
            unhi_o[(2*i+1)*ELEM_W +: ELEM_W] = b_i[(i+NL/2)*ELEM_W +: ELEM_W];
        end
    end

endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_alu_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int MIN_EW   = 8,
    parameter int CNT_W    = 7,
    parameter int MUL_EW   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [4:0]        opcode,
    input  logic [1:0]        lane_sel,
    input  logic [1:0]        sat_sel,
    input  logic [CNT_W-1:0]  shamt,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              illegal
);
    localparam int NSIZE = 4;

    typedef struct packed {
        logic              vld;
        logic              bad;
        logic [DATA_W-1:0] res;
    } alu_state_t;

    alu_state_t st_d, st_q;

    logic [DATA_W-1:0] sum_w [NSIZE];
    logic [DATA_W-1:0] eq_w  [NSIZE];
    logic [DATA_W-1:0] gt_w  [NSIZE];
    logic [DATA_W-1:0] sh_w  [NSIZE];
    logic [DATA_W-1:0] pk_w  [NSIZE];
    logic [DATA_W-1:0] ul_w  [NSIZE];
    logic [DATA_W-1:0] uh_w  [NSIZE];
    logic [DATA_W-1:0] mlo_w, mhi_w, madd_w;
    logic [1:0]        sh_kind;
    logic              is_sub, is_usat;

    assign is_sub  = (opcode == OP_SUB);
    assign is_usat = (sat_sel == SAT_USG);

    always_comb begin
        case (opcode)
            OP_SHL:  sh_kind = SH_LEFT;
            OP_SHR:  sh_kind = SH_RLOG;
            default: sh_kind = SH_RARI;
        endcase
    end

    for (genvar k = 0; k < NSIZE; k++) begin : g_size
        localparam int EW = MIN_EW << k;

        simd_lane_arith #(.DATA_W(DATA_W), .ELEM_W(EW)) u_arith (
            .a_i(src_a), .b_i(src_b), .sub_i(is_sub), .sat_i(sat_sel),
            .sum_o(sum_w[k]), .eq_o(eq_w[k]), .gt_o(gt_w[k])
        );

        simd_lane_shift #(.DATA_W(DATA_W), .ELEM_W(EW), .CNT_W(CNT_W)) u_shift (
            .a_i(src_a), .cnt_i(shamt), .kind_i(sh_kind), .y_o(sh_w[k])
        );

        simd_lane_permute #(.DATA_W(DATA_W), .ELEM_W(EW)) u_perm (
            .a_i(src_a), .b_i(src_b), .usat_i(is_usat),
            .pack_o(pk_w[k]), .unlo_o(ul_w[k]), .unhi_o(uh_w[k])
        );
    end

    simd_mul16 #(.DATA_W(DATA_W), .ELEM_W(MUL_EW)) u_mul (
        .a_i(src_a), .b_i(src_b), .lo_o(mlo_w), .hi_o(mhi_w), .madd_o(madd_w)
    );

    always_comb begin
        logic              ok;
        logic [DATA_W-1:0] r;

        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.bad = 1'b0;
        ok       = 1'b0;
        r        = '0;

        if (in_valid) begin
            case (opcode)
                OP_ADD, OP_SUB: begin
                    ok = (lane_sel != LANE_D) && (sat_sel != SAT_BAD);
                    r  = sum_w[lane_sel];
                end
                OP_CMPEQ: begin
                    ok = (lane_sel != LANE_D);
                    r  = eq_w[lane_sel];
                end
                OP_CMPGT: begin
                    ok = (lane_sel != LANE_D);
                    r  = gt_w[lane_sel];
                end
                OP_MULLO: begin
                    ok = (lane_sel == LANE_H);
                    r  = mlo_w;
                end
                OP_MULHI: begin
                    ok = (lane_sel == LANE_H);
                    r  = mhi_w;
                end
                OP_MADD: begin
                    ok = (lane_sel == LANE_H);
                    r  = madd_w;
                end
                OP_PACK: begin
                    ok = ((lane_sel == LANE_H) || (lane_sel == LANE_W)) && (sat_sel != SAT_BAD);
                    r  = pk_w[lane_sel];
                end
                OP_UNPKLO: begin
                    ok = (lane_sel != LANE_D);
                    r  = ul_w[lane_sel];
                end
                OP_UNPKHI: begin
                    ok = (lane_sel != LANE_D);
                    r  = uh_w[lane_sel];
                end
                OP_SHL, OP_SHR: begin
                    ok = (lane_sel != LANE_B);
                    r  = sh_w[lane_sel];
                end
                OP_SAR: begin
                    ok = (lane_sel == LANE_H) || (lane_sel == LANE_W);
                    r  = sh_w[lane_sel];
                end
                OP_AND: begin
                    ok = (lane_sel == LANE_D);
                    r  = src_a & src_b;
                end
                OP_ANDN: begin
                    ok = (lane_sel == LANE_D);
                    r  = ~src_a & src_b;
                end
                OP_OR: begin
                    ok = (lane_sel == LANE_D);
                    r  = src_a | src_b;
                end
                OP_XOR: begin
                    ok = (lane_sel == LANE_D);
                    r  = src_a ^ src_b;
                end
                default: begin
                    ok = 1'b0;
                    r  = '0;
                end
            endcase
            st_d.bad = !ok;
            st_d.res = ok ? r : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign illegal   = st_q.bad;
    assign result    = st_q.res;

endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic [4:0]        opcode,
    input logic [1:0]        lane_sel,
    input logic [1:0]        sat_sel,
    input logic [CNT_W-1:0]  shamt,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              illegal
);

    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));

    p_illegal_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (out_valid && result == '0));

    p_add_wide_lane_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode <= 5'd1 && lane_sel == 2'd3) |=> illegal);

    p_self_equal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 5'd2 && lane_sel != 2'd3 && src_a == src_b) |=> (result == '1));

    p_usat_ceiling_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 5'd0 && sat_sel == 2'd2 && lane_sel != 2'd3 && src_a == '1)
        |=> (result == '1));

    p_and_word_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 5'd13 && lane_sel == 2'd3) |=> (result == $past(src_a & src_b)));

    p_xor_word_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 5'd16 && lane_sel == 2'd3) |=> (result == $past(src_a ^ src_b)));

    p_big_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opcode == 5'd10 || opcode == 5'd11) && lane_sel == 2'd3
         && shamt >= CNT_W'(DATA_W)) |=> (result == '0 && !illegal));

endmodule

bind simd_alu simd_alu_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_simd_alu.sv
`timescale 1ns/1ps
module sim_simd_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] src_a = '0, src_b = '0;
    logic [4:0]  opcode = '0;
    logic [1:0]  lane_sel = '0, sat_sel = '0;
    logic [6:0]  shamt = '0;
    logic        out_valid, illegal;
    logic [63:0] result;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    simd_alu u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
        .opcode(opcode), .lane_sel(lane_sel), .sat_sel(sat_sel), .shamt(shamt),
        .out_valid(out_valid), .result(result), .illegal(illegal)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive one operation at a falling edge; after the next falling edge the registered output is visible
    task automatic issue(input logic [4:0] op, input logic [1:0] ln, input logic [1:0] st,
                         input logic [63:0] a, input logic [63:0] b, input logic [6:0] sh);
        @(negedge clk);
        opcode = op; lane_sel = ln; sat_sel = st; src_a = a; src_b = b; shamt = sh;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run(input string tag, input logic [4:0] op, input logic [1:0] ln,
                       input logic [1:0] st, input logic [63:0] a, input logic [63:0] b,
                       input logic [6:0] sh, input logic [63:0] exp);
        issue(op, ln, st, a, b, sh);
        check(tag, result, exp);
        check({tag, " illegal"}, {63'd0, illegal}, 64'd0);
    endtask

    task automatic t_reset;
        check("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
        check("R1 reset illegal", {63'd0, illegal}, 64'd0);
        check("R1 reset result", result, 64'd0);
    endtask

    task automatic t_timing;
        logic [63:0] kept;
        issue(5'd0, 2'd1, 2'd0, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0003, 7'd0);
        check("R1 valid after strobe", {63'd0, out_valid}, 64'd1);
        kept = result;
        check("R1 result", kept, 64'h8);
        @(negedge clk);
        check("R1 valid drops", {63'd0, out_valid}, 64'd0);
        check("R1 result held", result, kept);
        @(negedge clk);
        check("R1 result held 2", result, kept);
    endtask

    task automatic t_wrap;
        run("R2 add8 wrap", 5'd0, 2'd0, 2'd0, 64'hFF, 64'h01, 7'd0, 64'h0);
        run("R2 add16 carry inside", 5'd0, 2'd1, 2'd0, 64'hFF, 64'h01, 7'd0, 64'h100);
        run("R2 sub32 borrow", 5'd1, 2'd2, 2'd0, 64'h0, 64'h1, 7'd0, 64'h0000_0000_FFFF_FFFF);
        run("R2 add8 all lanes", 5'd0, 2'd0, 2'd0, 64'h8080_8080_8080_8080,
            64'h8080_8080_8080_8080, 7'd0, 64'h0);
    endtask

    task automatic t_sat;
        run("R3 s8 add max", 5'd0, 2'd0, 2'd1, 64'h7F, 64'h01, 7'd0, 64'h7F);
        run("R3 s8 sub min", 5'd1, 2'd0, 2'd1, 64'h80, 64'h01, 7'd0, 64'h80);
        run("R3 s16 add", 5'd0, 2'd1, 2'd1, 64'h7FFF, 64'h7FFF, 7'd0, 64'h7FFF);
        run("R4 u8 add ceiling", 5'd0, 2'd0, 2'd2, 64'hFF, 64'h01, 7'd0, 64'hFF);
        run("R4 u8 sub floor", 5'd1, 2'd0, 2'd2, 64'h00, 64'h01, 7'd0, 64'h00);
        run("R4 u8 add plain", 5'd0, 2'd0, 2'd2, 64'h10, 64'h20, 7'd0, 64'h30);
    endtask

    task automatic t_cmp;
        run("R5 eq8", 5'd2, 2'd0, 2'd0, 64'h0011_2233_4455_6677, 64'h0011_FF33_AA55_6677,
            7'd0, 64'hFFFF_00FF_00FF_FFFF);
        run("R5 gt16 signed", 5'd3, 2'd1, 2'd0, 64'h0001_FFFF_8000_7FFF,
            64'h0000_0000_7FFF_8000, 7'd0, 64'hFFFF_0000_0000_FFFF);
    endtask

    task automatic t_mul;
        run("R6 mul low", 5'd4, 2'd1, 2'd0, 64'h0002_FFFF_0100_7FFF, 64'h0003_0002_0100_7FFF,
            7'd0, 64'h0006_FFFE_0000_0001);
        run("R6 mul high", 5'd5, 2'd1, 2'd0, 64'h0002_FFFF_0100_7FFF, 64'h0003_0002_0100_7FFF,
            7'd0, 64'h0000_FFFF_0001_3FFF);
        run("R7 madd", 5'd6, 2'd1, 2'd0, 64'h0002_FFFF_0100_7FFF, 64'h0003_0002_0100_7FFF,
            7'd0, 64'h0000_0004_4000_0001);
    endtask

    task automatic t_pack;
        run("R8 pack16 signed", 5'd7, 2'd1, 2'd0, 64'h0005_FF80_0100_FF00, 64'h7F,
            7'd0, 64'h0000_007F_0580_7F80);
        run("R8 pack16 unsigned", 5'd7, 2'd1, 2'd2, 64'h0005_FF80_0100_FF00, 64'h7F,
            7'd0, 64'h0000_007F_0500_FF00);
        run("R8 pack32 signed", 5'd7, 2'd2, 2'd1, 64'h0000_0000_0001_2345,
            64'hFFFF_FFFF_FFFF_8000, 7'd0, 64'hFFFF_8000_0000_7FFF);
    endtask

    task automatic t_unpack;
        run("R9 unpack lo8", 5'd8, 2'd0, 2'd0, 64'hA7A6_A5A4_A3A2_A1A0, 64'hB7B6_B5B4_B3B2_B1B0,
            7'd0, 64'hB3A3_B2A2_B1A1_B0A0);
        run("R9 unpack hi16", 5'd9, 2'd1, 2'd0, 64'hA7A6_A5A4_A3A2_A1A0, 64'hB7B6_B5B4_B3B2_B1B0,
            7'd0, 64'hB7B6_A7A6_B5B4_A5A4);
        run("R9 unpack lo32", 5'd8, 2'd2, 2'd0, 64'hA7A6_A5A4_A3A2_A1A0, 64'hB7B6_B5B4_B3B2_B1B0,
            7'd0, 64'hB3B2_B1B0_A3A2_A1A0);
    endtask

    task automatic t_shift;
        run("R10 shl16 by 4", 5'd10, 2'd1, 2'd0, 64'h8001_1234_00FF_F00F, 64'h0, 7'd4,
            64'h0010_2340_0FF0_00F0);
        run("R10 shr32 by 8", 5'd11, 2'd2, 2'd0, 64'h8000_0000_0000_00FF, 64'h0, 7'd8,
            64'h0080_0000_0000_0000);
        run("R10 shl16 by 16", 5'd10, 2'd1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 7'd16, 64'h0);
        run("R10 shr64 by 63", 5'd11, 2'd3, 2'd0, 64'h8000_0000_0000_0000, 64'h0, 7'd63, 64'h1);
        run("R10 shr64 by 64", 5'd11, 2'd3, 2'd0, 64'h8000_0000_0000_0000, 64'h0, 7'd64, 64'h0);
        run("R11 sar16 by 4", 5'd12, 2'd1, 2'd0, 64'h8000_7FF0_FFFF_0010, 64'h0, 7'd4,
            64'hF800_07FF_FFFF_0001);
        run("R11 sar32 by 40", 5'd12, 2'd2, 2'd0, 64'h8000_0000_7FFF_FFFF, 64'h0, 7'd40,
            64'hFFFF_FFFF_0000_0000);
    endtask

    task automatic t_logic;
        run("R12 and", 5'd13, 2'd3, 2'd0, 64'hFF00_FF00_F0F0_F0F0, 64'h0F0F_0F0F_FFFF_0000,
            7'd0, 64'h0F00_0F00_F0F0_0000);
        run("R12 andnot", 5'd14, 2'd3, 2'd0, 64'hFF00_FF00_F0F0_F0F0, 64'h0F0F_0F0F_FFFF_0000,
            7'd0, 64'h000F_000F_0F0F_0000);
        run("R12 or", 5'd15, 2'd3, 2'd0, 64'hFF00_FF00_F0F0_F0F0, 64'h0F0F_0F0F_FFFF_0000,
            7'd0, 64'hFF0F_FF0F_FFFF_F0F0);
        run("R12 xor", 5'd16, 2'd3, 2'd0, 64'hFF00_FF00_F0F0_F0F0, 64'h0F0F_0F0F_FFFF_0000,
            7'd0, 64'hF00F_F00F_0F0F_F0F0);
    endtask

    task automatic t_illegal;
        issue(5'd0, 2'd3, 2'd0, 64'h1, 64'h1, 7'd0);
        check("R13 add64 result", result, 64'h0);
        check("R13 add64 flag", {63'd0, illegal}, 64'd1);
        @(negedge clk);
        check("R13 flag one cycle", {63'd0, illegal}, 64'd0);
        issue(5'd31, 2'd1, 2'd0, 64'hFFFF, 64'hFFFF, 7'd0);
        check("R13 bad opcode flag", {63'd0, illegal}, 64'd1);
        check("R13 bad opcode result", result, 64'h0);
        issue(5'd4, 2'd0, 2'd0, 64'h3, 64'h3, 7'd0);
        check("R13 mul8 flag", {63'd0, illegal}, 64'd1);
        issue(5'd0, 2'd0, 2'd3, 64'h3, 64'h3, 7'd0);
        check("R13 sat code 3 flag", {63'd0, illegal}, 64'd1);
        check("R13 sat code 3 result", result, 64'h0);
        run("R13 legal after illegal", 5'd15, 2'd3, 2'd0, 64'h1, 64'h2, 7'd0, 64'h3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_timing();
        t_wrap();
        t_sat();
        t_cmp();
        t_mul();
        t_pack();
        t_unpack();
        t_shift();
        t_logic();
        t_illegal();
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule